// File: doc/BRIEF.md
# Call and Stack Pointer Controller

This block owns the stack pointer of a small byte-oriented processor and turns the four stack-related operations (push of a byte, pop of a byte, subroutine call and subroutine return) into a short sequence of accesses to an external on-chip data RAM. The stack grows upward. A push first increments the pointer and then writes. A pop first reads and then decrements. A call stores the two bytes of its return address, low byte first, and then supplies the new program counter. A return reads the two bytes back in the opposite order and rebuilds the program counter.

A command is given by `cmd_valid` with a 3-bit operation code, the byte to push, the PC of the calling instruction and the call target. The controller makes at most one RAM access per clock. The RAM write port is `ram_we`/`ram_waddr`/`ram_wdata`. The read port is `ram_re`/`ram_raddr`, and the RAM returns `ram_rdata` one clock after the request. One cycle after the last access of a sequence the controller raises `done`. For calls and returns it also raises `pc_load` and presents the new PC on `pc_out`. While a sequence runs, further commands are ignored.

The state machine uses the states IDLE, PUSH_WR, POP_RD, CALL_LO, CALL_HI, RET_HI, RET_LO and FIN. It makes these transitions:
- IDLE to PUSH_WR on an accepted push.
- IDLE to POP_RD on a pop.
- IDLE to CALL_LO on either call.
- IDLE to RET_HI on a return.
- PUSH_WR to FIN and POP_RD to FIN.
- CALL_LO to CALL_HI, then CALL_HI to FIN.
- RET_HI to RET_LO, then RET_LO to FIN.
- FIN to IDLE, always.

Top module: `stack_call_ctrl`

## Requirements
- R1: After reset the stack pointer is 07h, no RAM access is requested and `done` and `pc_load` are low.
- R2: Push (op code 0): in the cycle after acceptance the block writes `push_data` at address SP+1, and SP becomes SP+1.
- R3: Pop (op code 1): in the cycle after acceptance the block reads address SP. In the next cycle `pop_data` shows the byte the RAM returned, and SP becomes SP-1. `pop_data` holds that byte until the next pop.
- R4: Long call (op code 2): the return address is `pc_in`+3. Its low byte is written at SP+1 in the first cycle after acceptance and its high byte at SP+2 in the second cycle. Then `pc_out` equals `target_in`.
- R5: Absolute call (op code 3): the return address is `pc_in`+2 and is stored as in R4. The new PC is bits 15..11 of that return address joined with bits 10..0 of `target_in`.
- R6: Return (op code 4): the block reads the high byte at SP in the first cycle after acceptance and the low byte at SP-1 in the second cycle. Then `pc_out` is {high, low} and SP has dropped by 2.
- R7: `done` is high for exactly one cycle, the cycle after the final RAM access of a sequence. `pc_load` is high in that same cycle for calls and returns only.
- R8: A command presented while a sequence is in progress is ignored, and so is an op code of 5, 6 or 7. No RAM access and no `done` follow from it.
- R9: The stack pointer wraps modulo 256 in both directions.
- R10: The block never requests a RAM write and a RAM read in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | Operation: 0 push, 1 pop, 2 long call, 3 absolute call, 4 return |
| push_data | input | 8 | Byte to push |
| pc_in | input | 16 | PC of the calling instruction |
| target_in | input | 16 | Call target (low 11 bits used by the absolute call) |
| ram_we | output | 1 | RAM write enable |
| ram_waddr | output | 8 | RAM write address |
| ram_wdata | output | 8 | RAM write data |
| ram_re | output | 1 | RAM read request |
| ram_raddr | output | 8 | RAM read address |
| ram_rdata | input | 8 | RAM read data, valid one cycle after the request |
| pop_data | output | 8 | Popped byte |
| pc_out | output | 16 | New program counter |
| pc_load | output | 1 | Load `pc_out` into the PC |
| done | output | 1 | Sequence complete |

## Verification
The bench goes after pointer wrap at both ends. It pops from 00h to FFh and runs a call and a return that straddle the FFh/00h boundary. A design with a saturating or mis-sized pointer would read or write the wrong address there. It runs an absolute call whose return address crosses a 2 KB page. A design that took the page bits from `pc_in` instead of the return address would jump into the previous page. Commands held during a busy sequence and reserved op codes must leave the RAM ports silent. If either were accepted, an extra write or a second `done` would appear. The byte order of calls and returns is checked address by address, so a design with swapped low and high bytes would return to a byte-reversed PC.

// File: rtl/stk_pkg.sv
package stk_pkg;

    typedef enum logic [2:0] {
        OP_PUSH  = 3'd0,
        OP_POP   = 3'd1,
        OP_LCALL = 3'd2,
        OP_ACALL = 3'd3,
        OP_RET   = 3'd4
    } stk_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PUSH_WR,
        S_POP_RD,
        S_CALL_LO,
        S_CALL_HI,
        S_RET_HI,
        S_RET_LO,
        S_FIN
    } stk_state_e;

    typedef enum logic [1:0] {
        WSEL_BYTE,
        WSEL_RET_LO,
        WSEL_RET_HI
    } wsel_e;

endpackage

// File: rtl/stk_ptr.sv
module stk_ptr #(
    parameter int SP_W   = 8,
    parameter int SP_RST = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            inc,
    input  logic            dec,
    output logic [SP_W-1:0] sp
);
    logic [SP_W-1:0] sp_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            sp_q <= SP_W'(SP_RST);
        else if (inc)
            sp_q <= sp_q + SP_W'(1);
        else if (dec)
            sp_q <= sp_q - SP_W'(1);
    end

    assign sp = sp_q;

    // R10: the sequencer never asks for both directions at once
    a_r10_no_inc_dec: assert property (@(posedge clk) disable iff (!rst_n)
        !(inc && dec));

    // R2 / R9: increment is modulo 2^SP_W
    a_r2_sp_step_up: assert property (@(posedge clk) disable iff (!rst_n)
        inc |=> sp_q == $past(sp_q) + SP_W'(1));

    // R3 / R9: decrement is modulo 2^SP_W
    a_r3_sp_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !inc) |=> sp_q == $past(sp_q) - SP_W'(1));

endmodule

// File: rtl/call_addr_gen.sv
module call_addr_gen #(
    parameter int PC_W   = 16,
    parameter int PAGE_W = 11
) (
    input  logic [PC_W-1:0] pc_in,
    input  logic [PC_W-1:0] target_in,
    input  logic            is_abs,
    output logic [PC_W-1:0] ret_pc,
    output logic [PC_W-1:0] dest_pc
);
    localparam logic [PC_W-1:0] LEN_ABS  = PC_W'(2);
    localparam logic [PC_W-1:0] LEN_LONG = PC_W'(3);

    assign ret_pc = pc_in + (is_abs ? LEN_ABS : LEN_LONG);

    generate
        if (PAGE_W < PC_W) begin : g_paged
            assign dest_pc = is_abs ? {ret_pc[PC_W-1:PAGE_W], target_in[PAGE_W-1:0]}
                                    : target_in;
        end else begin : g_flat
            assign dest_pc = target_in;
        end
    endgenerate

endmodule

// File: rtl/stk_fsm.sv
module stk_fsm
    import stk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [2:0] cmd_op,
    output logic       accept,
    output logic       is_abs,
    output logic       sp_inc,
    output logic       sp_dec,
    output logic       wr_en,
    output logic       rd_en,
    output wsel_e      wsel,
    output logic       cap_hi,
    output logic       fin,
    output stk_op_e    op_q
);
    stk_state_e state_q, state_d;
    stk_op_e    op_in;

    assign op_in  = stk_op_e'(cmd_op);
    assign accept = (state_q == S_IDLE) && cmd_valid && (cmd_op <= 3'd4);
    assign is_abs = (op_in == OP_ACALL);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            op_q    <= OP_PUSH;
        end else begin
            state_q <= state_d;
            if (accept)
                op_q <= op_in;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (accept) begin
                    unique case (op_in)
                        OP_PUSH:           state_d = S_PUSH_WR;
                        OP_POP:            state_d = S_POP_RD;
                        OP_LCALL, OP_ACALL: state_d = S_CALL_LO;
                        OP_RET:            state_d = S_RET_HI;
                        default:           state_d = S_IDLE;
                    endcase
                end
            end
            S_PUSH_WR: state_d = S_FIN;
            S_POP_RD:  state_d = S_FIN;
            S_CALL_LO: state_d = S_CALL_HI;
            S_CALL_HI: state_d = S_FIN;
            S_RET_HI:  state_d = S_RET_LO;
            S_RET_LO:  state_d = S_FIN;
            S_FIN:     state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        sp_inc = 1'b0;
        sp_dec = 1'b0;
        wr_en  = 1'b0;
        rd_en  = 1'b0;
        wsel   = WSEL_BYTE;
        cap_hi = 1'b0;
        fin    = 1'b0;
        unique case (state_q)
            S_IDLE:
                sp_inc = accept && (op_in inside {OP_PUSH, OP_LCALL, OP_ACALL});
            S_PUSH_WR: begin
                wr_en = 1'b1;
                wsel  = WSEL_BYTE;
            end
            S_POP_RD: begin
                rd_en  = 1'b1;
                sp_dec = 1'b1;
            end
            S_CALL_LO: begin
                wr_en  = 1'b1;
                wsel   = WSEL_RET_LO;
                sp_inc = 1'b1;
            end
            S_CALL_HI: begin
                wr_en = 1'b1;
                wsel  = WSEL_RET_HI;
            end
            S_RET_HI: begin
                rd_en  = 1'b1;
                sp_dec = 1'b1;
            end
            S_RET_LO: begin
                rd_en  = 1'b1;
                sp_dec = 1'b1;
                cap_hi = 1'b1;
            end
            S_FIN:
                fin = 1'b1;
            default: ;
        endcase
    end

    // R6: return always reads twice in a row
    a_r6_ret_two_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RET_HI) |=> (state_q == S_RET_LO));

    // R4: call writes low byte then high byte
    a_r4_call_lo_then_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_CALL_LO) |=> (state_q == S_CALL_HI));

    // R8: the finishing cycle is always followed by idle
    a_r8_fin_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> (state_q == S_IDLE));

endmodule

// File: rtl/stack_call_ctrl.sv
module stack_call_ctrl
    import stk_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int SP_RESET = 7,
    parameter int PAGE_W   = 11
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    input  logic [2:0]          cmd_op,
    input  logic [DATA_W-1:0]   push_data,
    input  logic [2*DATA_W-1:0] pc_in,
    input  logic [2*DATA_W-1:0] target_in,
    output logic                ram_we,
    output logic [DATA_W-1:0]   ram_waddr,
    output logic [DATA_W-1:0]   ram_wdata,
    output logic                ram_re,
    output logic [DATA_W-1:0]   ram_raddr,
    input  logic [DATA_W-1:0]   ram_rdata,
    output logic [DATA_W-1:0]   pop_data,
    output logic [2*DATA_W-1:0] pc_out,
    output logic                pc_load,
    output logic                done
);
    localparam int PC_W = 2 * DATA_W;
    localparam int SP_W = DATA_W;

    logic            accept, is_abs, sp_inc, sp_dec, wr_en, rd_en, cap_hi, fin;
    wsel_e           wsel;
    stk_op_e         op_q;
    logic [SP_W-1:0] sp;
    logic [PC_W-1:0] ret_pc, dest_pc;

    logic [DATA_W-1:0] byte_q, hi_q, pop_q;
    logic [PC_W-1:0]   ret_q, dest_q, pc_q;
    logic              fin_pop, fin_ret, fin_call;

    stk_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .accept    (accept),
        .is_abs    (is_abs),
        .sp_inc    (sp_inc),
        .sp_dec    (sp_dec),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .wsel      (wsel),
        .cap_hi    (cap_hi),
        .fin       (fin),
        .op_q      (op_q)
    );

    stk_ptr #(.SP_W(SP_W), .SP_RST(SP_RESET)) u_sp (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (sp_inc),
        .dec   (sp_dec),
        .sp    (sp)
    );

    call_addr_gen #(.PC_W(PC_W), .PAGE_W(PAGE_W)) u_addr (
        .pc_in     (pc_in),
        .target_in (target_in),
        .is_abs    (is_abs),
        .ret_pc    (ret_pc),
        .dest_pc   (dest_pc)
    );

    assign fin_pop  = fin && (op_q == OP_POP);
    assign fin_ret  = fin && (op_q == OP_RET);
    assign fin_call = fin && (op_q inside {OP_LCALL, OP_ACALL});

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_q <= '0;
            ret_q  <= '0;
            dest_q <= '0;
            hi_q   <= '0;
            pop_q  <= '0;
            pc_q   <= '0;
        end else begin
            if (accept) begin
                byte_q <= push_data;
                ret_q  <= ret_pc;
                dest_q <= dest_pc;
            end
            if (cap_hi)
                hi_q <= ram_rdata;
            if (fin_pop)
                pop_q <= ram_rdata;
            if (fin_ret)
                pc_q <= {hi_q, ram_rdata};
            else if (fin_call)
                pc_q <= dest_q;
        end
    end

    always_comb begin
        unique case (wsel)
            WSEL_RET_LO: ram_wdata = ret_q[DATA_W-1:0];
            WSEL_RET_HI: ram_wdata = ret_q[PC_W-1:DATA_W];
            default:     ram_wdata = byte_q;
        endcase
    end

    assign ram_we    = wr_en;
    assign ram_waddr = sp;
    assign ram_re    = rd_en;
    assign ram_raddr = sp;

    assign pop_data = fin_pop ? ram_rdata : pop_q;
    assign pc_out   = fin_ret  ? {hi_q, ram_rdata} :
                      fin_call ? dest_q : pc_q;
    assign pc_load  = fin_ret || fin_call;
    assign done     = fin;

    // R10: one RAM access per cycle at most
    a_r10_one_access: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_we && ram_re));

    // R7: done follows a RAM access
    a_r7_done_after_access: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(ram_we || ram_re));

    // R7: pc_load only together with done
    a_r7_pcload_in_done: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> done);

    // R8: nothing happens in the cycle after done
    a_r8_quiet_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !(ram_we || ram_re || done));

endmodule

// File: tb/tb_stack_call_ctrl.sv
`timescale 1ns/1ps
module tb_stack_call_ctrl;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_valid;
    logic [2:0]  cmd_op;
    logic [7:0]  push_data;
    logic [15:0] pc_in, target_in;
    logic        ram_we, ram_re, pc_load, done;
    logic [7:0]  ram_waddr, ram_wdata, ram_raddr, ram_rdata, pop_data;
    logic [15:0] pc_out;

    always #2.5 clk = ~clk;

    stack_call_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .push_data(push_data), .pc_in(pc_in), .target_in(target_in),
        .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
        .ram_re(ram_re), .ram_raddr(ram_raddr), .ram_rdata(ram_rdata),
        .pop_data(pop_data), .pc_out(pc_out), .pc_load(pc_load), .done(done)
    );

    // behavioural RAM seen by the design
    logic [7:0] bram [256];
    always @(posedge clk) begin
        if (ram_we) bram[ram_waddr] <= ram_wdata;
        if (ram_re) ram_rdata <= bram[ram_raddr];
    end

    // reference model
    int         rsp;
    logic [7:0] rmem [256];

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  ended   = 0;

    task automatic chk(input string req, input string what,
                       input logic [39:0] act, input logic [39:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // compare all RAM / strobe outputs of the current cycle
    task automatic step(input bit we, input logic [7:0] wa, input logic [7:0] wd,
                        input bit re, input logic [7:0] ra,
                        input bit dn, input bit pl, input string req);
        logic [39:0] a, e;
        a = {13'd0, ram_we, (ram_we === 1'b1) ? ram_waddr : 8'h00,
             (ram_we === 1'b1) ? ram_wdata : 8'h00,
             ram_re, (ram_re === 1'b1) ? ram_raddr : 8'h00, done, pc_load};
        e = {13'd0, we, we ? wa : 8'h00, we ? wd : 8'h00, re, re ? ra : 8'h00, dn, pl};
        chk(req, "ports", a, e);
    endtask

    task automatic t_push(input logic [7:0] b, input bit hold, input string req);
        cmd_valid = 1; cmd_op = 3'd0; push_data = b;
        @(negedge clk);
        if (hold) begin cmd_op = 3'd2; pc_in = 16'h5555; push_data = ~b; end
        else cmd_valid = 0;
        rsp = (rsp + 1) & 255; rmem[rsp] = b;
        step(1, rsp[7:0], b, 0, 0, 0, 0, req);
        @(negedge clk); cmd_valid = 0;
        step(0, 0, 0, 0, 0, 1, 0, "R7");
        @(negedge clk);
        step(0, 0, 0, 0, 0, 0, 0, "R8");
    endtask

    task automatic t_pop(input string req);
        logic [7:0] expb;
        cmd_valid = 1; cmd_op = 3'd1;
        @(negedge clk); cmd_valid = 0;
        step(0, 0, 0, 1, rsp[7:0], 0, 0, req);
        expb = rmem[rsp];
        rsp = (rsp - 1) & 255;
        @(negedge clk);
        step(0, 0, 0, 0, 0, 1, 0, "R7");
        chk("R3", "pop_data", {32'd0, pop_data}, {32'd0, expb});
        @(negedge clk);
        step(0, 0, 0, 0, 0, 0, 0, "R8");
        chk("R3", "pop_data hold", {32'd0, pop_data}, {32'd0, expb});
    endtask

    task automatic t_call(input logic [15:0] pc, input logic [15:0] tgt,
                          input bit abs, input string req);
        logic [15:0] ret, dst;
        ret = pc + (abs ? 16'd2 : 16'd3);
        dst = abs ? {ret[15:11], tgt[10:0]} : tgt;
        cmd_valid = 1; cmd_op = abs ? 3'd3 : 3'd2; pc_in = pc; target_in = tgt;
        @(negedge clk); cmd_valid = 0;
        rsp = (rsp + 1) & 255; rmem[rsp] = ret[7:0];
        step(1, rsp[7:0], ret[7:0], 0, 0, 0, 0, req);
        @(negedge clk);
        rsp = (rsp + 1) & 255; rmem[rsp] = ret[15:8];
        step(1, rsp[7:0], ret[15:8], 0, 0, 0, 0, req);
        @(negedge clk);
        step(0, 0, 0, 0, 0, 1, 1, "R7");
        chk(req, "pc_out", {24'd0, pc_out}, {24'd0, dst});
        @(negedge clk);
        step(0, 0, 0, 0, 0, 0, 0, "R8");
    endtask

    task automatic t_ret(input string req);
        logic [15:0] expc;
        cmd_valid = 1; cmd_op = 3'd4;
        @(negedge clk); cmd_valid = 0;
        step(0, 0, 0, 1, rsp[7:0], 0, 0, req);
        expc[15:8] = rmem[rsp];
        rsp = (rsp - 1) & 255;
        @(negedge clk);
        step(0, 0, 0, 1, rsp[7:0], 0, 0, req);
        expc[7:0] = rmem[rsp];
        rsp = (rsp - 1) & 255;
        @(negedge clk);
        step(0, 0, 0, 0, 0, 1, 1, "R7");
        chk(req, "pc_out", {24'd0, pc_out}, {24'd0, expc});
        @(negedge clk);
        step(0, 0, 0, 0, 0, 0, 0, "R8");
        chk("R6", "pc_out hold", {24'd0, pc_out}, {24'd0, expc});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            n_tests++; n_fail++;
            $display("FAIL R7 watchdog actual=hung expected=complete");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) begin bram[i] = 8'h00; rmem[i] = 8'h00; end
        rst_n = 0; cmd_valid = 0; cmd_op = 0; push_data = 0; pc_in = 0; target_in = 0;
        rsp = 7;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        step(0, 0, 0, 0, 0, 0, 0, "R1");

        t_push(8'hA5, 0, "R1");            // first write lands at 08h
        t_push(8'h3C, 1, "R8");            // command held while busy
        t_call(16'h1234, 16'hABCD, 0, "R4");
        t_call(16'hC7FF, 16'h06C2, 1, "R5");   // return address crosses a page
        t_ret("R6");
        t_ret("R6");
        t_pop("R3");
        t_pop("R3");

        // reserved op codes
        for (int op = 5; op < 8; op++) begin
            cmd_valid = 1; cmd_op = op[2:0];
            @(negedge clk); cmd_valid = 0;
            step(0, 0, 0, 0, 0, 0, 0, "R8");
            @(negedge clk);
            step(0, 0, 0, 0, 0, 0, 0, "R8");
        end

        // walk down to 00h and wrap to FFh
        while (rsp != 0) t_pop("R3");
        t_pop("R9");
        chk("R9", "model sp", 40'(rsp), 40'd255);
        t_push(8'h77, 0, "R9");            // lands at 00h
        t_pop("R9");
        t_call(16'hFFFE, 16'h0100, 0, "R9");   // writes FFh? no: 00h,01h
        t_ret("R9");
        t_push(8'h11, 0, "R2");
        t_push(8'h22, 0, "R2");
        t_pop("R3");
        t_pop("R3");

        if (!ended) begin
            ended = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule